// File: doc/BRIEF.md
# Addressable Serial Attenuator Control Port

This block takes a 16-bit control frame from a three-wire serial bus made of a data line, a shift clock and a latch-enable line. It keeps a 7-bit attenuation code that drives a step attenuator core. The frame carries two fields. One is a target address, which is compared with three static strap inputs. The other is an attenuation word. Because a frame addressed to another device leaves the state alone, several attenuators can share one bus and each is picked out by its straps.

All three bus lines are asynchronous to the fast system clock, so each one passes through a synchronizer. The rising edges of the shift clock and of latch enable are found in the system clock domain. A rising shift-clock edge moves one data bit into the frame register, but only while latch enable is low. A rising latch-enable edge decodes the register. The held code changes only when the address matches and the reserved top bit of the attenuation word is clear. Each accepted change gives a one-cycle `updated` strobe. A matching frame with the reserved bit set gives a one-cycle `frame_err` strobe instead.

Top module: `serial_atten_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `atten_code` is 7'h7F (the maximum, 31.75 dB), and `updated` and `frame_err` are 0.
- R2: Frame bits are shifted in least significant first. Only the last 16 bits shifted before the latch count. Frame bits 7:0 form the attenuation word: bits 6:0 are the code (dB times 4, with bit weights 0.25, 0.5, 1, 2, 4, 8 and 16 dB) and bit 7 is reserved. Frame bits 15:8 form the address word.
- R3: Only frame bits 10:8 are compared with `addr_strap[2:0]`. Frame bits 15:11 have no effect.
- R4: A latched frame whose bits 10:8 differ from `addr_strap` leaves `atten_code` unchanged and raises neither strobe.
- R5: A latched frame with a matching address and bit 7 set leaves `atten_code` unchanged, pulses `frame_err` for one cycle, and does not pulse `updated`.
- R6: `atten_code` changes only as a result of a latch. Shifting data in never moves it.
- R7: `updated` pulses for one cycle when an accepted frame carries a code that differs from the held code. An accepted frame that carries the held code gives no pulse.
- R8: The effect of a latch shows on the outputs after the third rising edge of `clk`, counting the first edge that samples `ser_latch` high. Each bus line level must be held for at least 2 `clk` cycles.
- R9: A bit is shifted only on a rising edge of `ser_clk` seen while `ser_latch` is low. If `ser_clk` and `ser_latch` rise in the same cycle, the bit is not shifted and the latch decodes the register as it stood.
- R10: Each rising edge of `ser_latch` gives exactly one decode. Holding `ser_latch` high gives no repeated decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, least significant bit first |
| ser_latch | input | 1 | Latch enable; low while shifting, rising edge decodes |
| addr_strap | input | 3 | Static device address straps |
| atten_code | output | 7 | Held attenuation code, 0.25 dB per LSB |
| updated | output | 1 | One-cycle strobe when an accepted frame changes the code |
| frame_err | output | 1 | One-cycle strobe for a matching frame with the reserved bit set |

## Verification
A shift-clock rising edge and a latch-enable rising edge can be detected in the same system cycle. The bench provokes this by shifting 15 bits of a new frame and then raising both lines in the same cycle. The expected code is taken from the register as it stood, with the fifteen new bits above the one remaining old bit, so a design that shifts before decoding gives a different code. A behavioural model fed from the raw pins is also compared on every clock, which confirms the exact latch latency and that the simultaneous bit is dropped.

// File: rtl/atten_pkg.sv
package atten_pkg;

    parameter int CODE_W      = 7;
    parameter int ATT_W       = 8;
    parameter int ADDR_W      = 3;
    parameter int ADDR_WORD_W = 8;
    localparam int FRAME_W    = ATT_W + ADDR_WORD_W;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_MAX = '1;

    typedef enum int unsigned {
        LN_CLK   = 0,
        LN_DATA  = 1,
        LN_LATCH = 2,
        LN_COUNT = 3
    } line_e;

    typedef struct packed {
        logic [ADDR_WORD_W-1:0] addr_word;
        logic [ATT_W-1:0]       att_word;
    } frame_t;

    typedef struct packed {
        logic  hit;
        logic  bad;
        code_t code;
    } decode_t;

    function automatic decode_t decode_frame(frame_t f, logic [ADDR_W-1:0] strap);
        decode_t d;
        d.hit  = (f.addr_word[ADDR_W-1:0] == strap);
        d.bad  = f.att_word[ATT_W-1];
        d.code = f.att_word[CODE_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= g_stage[g-1].q;
            end
        end
    end

    assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/atten_rise.sv
module atten_rise (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);

    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;

endmodule

// File: rtl/atten_shift.sv
module atten_shift
    import atten_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   shift_en,
    input  logic   bit_in,
    output frame_t frame_q
);

    logic [FRAME_W-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst)           bits_q <= '0;
        else if (shift_en) bits_q <= {bit_in, bits_q[FRAME_W-1:1]};
    end

    assign frame_q = frame_t'(bits_q);

endmodule

// File: rtl/atten_state.sv
module atten_state
    import atten_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  frame_t            frame,
    input  logic [ADDR_W-1:0] strap,
    output code_t             code,
    output logic              updated,
    output logic              frame_err
);

    decode_t dec;

    assign dec = decode_frame(frame, strap);

    always_ff @(posedge clk) begin
        if (rst) begin
            code      <= CODE_MAX;
            updated   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            updated   <= 1'b0;
            frame_err <= 1'b0;
            if (load && dec.hit) begin
                if (dec.bad) begin
                    frame_err <= 1'b1;
                end else begin
                    code    <= dec.code;
                    updated <= (dec.code != code);
                end
            end
        end
    end

endmodule

// File: rtl/serial_atten_ctrl.sv
module serial_atten_ctrl
    import atten_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_latch,
    input  logic [ADDR_W-1:0] addr_strap,
    output logic [CODE_W-1:0] atten_code,
    output logic              updated,
    output logic              frame_err
);

    localparam int LINES = int'(LN_COUNT);

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;
    logic             clk_rise;
    logic             le_rise;
    logic             shift_en;
    frame_t           frame_q;

    always_comb begin
        raw_lines           = '0;
        raw_lines[LN_CLK]   = ser_clk;
        raw_lines[LN_DATA]  = ser_data;
        raw_lines[LN_LATCH] = ser_latch;
    end

    atten_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    atten_rise u_clk_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lines[LN_CLK]),
        .rise (clk_rise)
    );

    atten_rise u_latch_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lines[LN_LATCH]),
        .rise (le_rise)
    );

    assign shift_en = clk_rise & ~sync_lines[LN_LATCH];

    atten_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_in   (sync_lines[LN_DATA]),
        .frame_q  (frame_q)
    );

    atten_state u_state (
        .clk       (clk),
        .rst       (rst),
        .load      (le_rise),
        .frame     (frame_q),
        .strap     (addr_strap),
        .code      (atten_code),
        .updated   (updated),
        .frame_err (frame_err)
    );

endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk
    import atten_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              le_rise,
    input frame_t            frame,
    input logic [ADDR_W-1:0] addr_strap,
    input logic [CODE_W-1:0] atten_code,
    input logic              updated,
    input logic              frame_err
);

    decode_t seen;

    assign seen = decode_frame(frame, addr_strap);

    // R1
    reset_max_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (atten_code == CODE_MAX && !updated && !frame_err));

    // R6
    code_moves_on_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(atten_code) |-> $past(le_rise));

    // R3
    accept_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        updated |-> ($past(seen.hit && !seen.bad) && atten_code == $past(seen.code)));

    // R5
    err_holds_code_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> ($stable(atten_code) && !updated && $past(seen.hit && seen.bad)));

    // R7
    updated_means_change_chk: assert property (@(posedge clk) disable iff (rst)
        updated |-> (atten_code != $past(atten_code)));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (updated || frame_err) |=> !(updated || frame_err));

endmodule

bind serial_atten_ctrl atten_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .le_rise    (le_rise),
    .frame      (frame_q),
    .addr_strap (addr_strap),
    .atten_code (atten_code),
    .updated    (updated),
    .frame_err  (frame_err)
);

// File: tb/serial_atten_ctrl_test.sv
module serial_atten_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       sclk, sdat, sle;
    logic [2:0] strap;
    logic [6:0] atten_code;
    logic       updated, frame_err;

    always #4 clk = ~clk;

    serial_atten_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .ser_clk    (sclk),
        .ser_data   (sdat),
        .ser_latch  (sle),
        .addr_strap (strap),
        .atten_code (atten_code),
        .updated    (updated),
        .frame_err  (frame_err)
    );

    int  compared   = 0;
    int  mismatched = 0;
    int  upd_cnt    = 0;
    int  err_cnt    = 0;
    int  cyc        = 0;
    bit  done       = 0;

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: pins are seen two cycles late, an edge one cycle later still
    logic [2:0]  hist[$];
    logic [15:0] m_frame;
    logic [6:0]  m_code;
    logic        m_upd, m_err;

    always @(posedge clk) begin
        logic [2:0] now_l, old_l;
        if (rst) begin
            hist    = {3'b000, 3'b000, 3'b000};
            m_frame = 16'h0000;
            m_code  = 7'h7F;
            m_upd   = 1'b0;
            m_err   = 1'b0;
        end else begin
            now_l = hist[1];
            old_l = hist[0];
            m_upd = 1'b0;
            m_err = 1'b0;
            if (now_l[2] && !old_l[2] && m_frame[10:8] == strap) begin
                if (m_frame[7]) m_err = 1'b1;
                else begin
                    m_upd  = (m_frame[6:0] != m_code);
                    m_code = m_frame[6:0];
                end
            end
            if (now_l[0] && !old_l[0] && !now_l[2])
                m_frame = {now_l[1], m_frame[15:1]};
            hist.push_back({sle, sdat, sclk});
            void'(hist.pop_front());
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check("R8 code per cycle", int'(atten_code), int'(m_code));
            check("R8 updated per cycle", int'(updated), int'(m_upd));
            check("R8 frame_err per cycle", int'(frame_err), int'(m_err));
            if (!rst) begin
                upd_cnt += int'(updated);
                err_cnt += int'(frame_err);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send_bits(logic [31:0] v, int n);
        for (int i = 0; i < n; i++) begin
            sdat = v[i];
            sclk = 1'b0;
            step(3);
            sclk = 1'b1;
            step(3);
        end
        sclk = 1'b0;
        step(3);
    endtask

    task automatic latch_frame();
        sle = 1'b1;
        step(4);
        sle = 1'b0;
        step(4);
    endtask

    function automatic logic [15:0] mk(logic [4:0] hi, logic [2:0] a, logic [7:0] w);
        return {hi, a, w};
    endfunction

    initial begin
        rst = 1'b1; sclk = 1'b0; sdat = 1'b0; sle = 1'b0; strap = 3'd3;
        step(5);
        check("R1 reset code", int'(atten_code), 127);
        check("R1 reset updated", int'(updated), 0);
        check("R1 reset frame_err", int'(frame_err), 0);
        rst = 1'b0;
        step(1);
        check("R1 code after release", int'(atten_code), 127);
        step(2);

        // 18.25 dB at address 3 -> code 73
        send_bits(32'(mk(5'b10110, 3'b011, 8'h49)), 16);
        check("R6 code during shifting", int'(atten_code), 127);
        sle = 1'b1;
        @(negedge clk);
        check("R8 code one edge after latch", int'(atten_code), 127);
        @(negedge clk);
        check("R8 code two edges after latch", int'(atten_code), 127);
        @(negedge clk);
        check("R8 code three edges after latch", int'(atten_code), 73);
        #1;
        step(1);
        sle = 1'b0;
        step(4);
        check("R2 code from frame", int'(atten_code), 73);
        check("R7 one updated pulse", upd_cnt, 1);

        // other address
        send_bits(32'(mk(5'b00000, 3'b101, 8'h22)), 16);
        latch_frame();
        check("R4 code held on mismatch", int'(atten_code), 73);
        check("R4 no updated on mismatch", upd_cnt, 1);
        check("R4 no frame_err on mismatch", err_cnt, 0);

        // upper address bits set, still matches
        send_bits(32'(mk(5'b11111, 3'b011, 8'h1C)), 16);
        latch_frame();
        check("R3 upper address bits ignored", int'(atten_code), 28);
        check("R7 updated count", upd_cnt, 2);

        // reserved bit set
        send_bits(32'(mk(5'b00000, 3'b011, 8'hC5)), 16);
        latch_frame();
        check("R5 code held on reserved bit", int'(atten_code), 28);
        check("R5 one frame_err pulse", err_cnt, 1);
        check("R5 no updated on reserved bit", upd_cnt, 2);

        // same code again
        send_bits(32'(mk(5'b00000, 3'b011, 8'h1C)), 16);
        latch_frame();
        check("R7 same code keeps value", int'(atten_code), 28);
        check("R7 no pulse on same code", upd_cnt, 2);

        // 20 bits: only the last 16 count
        send_bits({12'h000, mk(5'b00000, 3'b011, 8'h55), 4'b1010}, 20);
        latch_frame();
        check("R2 last sixteen bits count", int'(atten_code), 85);
        check("R7 updated after long frame", upd_cnt, 3);

        // latch held high while clocking data: nothing shifts, no repeat decode
        sle = 1'b1;
        step(4);
        send_bits(32'(mk(5'b00000, 3'b011, 8'h01)), 16);
        check("R10 no repeat decode while high", upd_cnt, 3);
        sle = 1'b0;
        step(4);
        latch_frame();
        check("R9 no shift while latch high", int'(atten_code), 85);
        check("R10 no extra updated", upd_cnt, 3);

        // shift clock and latch rising in the same cycle
        send_bits(32'(15'b00000_011_0_110011), 15);
        sdat = 1'b1;
        sclk = 1'b1;
        sle  = 1'b1;
        step(4);
        sclk = 1'b0;
        sle  = 1'b0;
        step(4);
        check("R9 simultaneous edge uses prior contents", int'(atten_code), 102);

        // strap changes
        strap = 3'd5;
        send_bits(32'(mk(5'b00000, 3'b011, 8'h10)), 16);
        latch_frame();
        check("R4 hold after strap change", int'(atten_code), 102);
        strap = 3'd0;
        send_bits(32'(mk(5'b01010, 3'b000, 8'h00)), 16);
        latch_frame();
        check("R3 match on address zero", int'(atten_code), 0);
        check("R7 updated on move to zero", upd_cnt, 5);

        step(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule